// File: doc/BRIEF.md
# Shifter-ALU with Condition Flags

This block is the arithmetic core of a small processor datapath. The second operand passes through a combinational barrel shifter before it reaches a 32-bit ALU. The shifter reports the last bit it pushed out, and the move operations turn that bit into their carry flag. The adder-based operations produce their own carry and overflow. A write-enabled register holds the four status flags (negative, zero, carry, overflow). A condition evaluator tests the held flags against a 4-bit branch condition code.

Everything except the flag register is combinational. In one cycle the caller presents the operands, the shift control, the operation and the condition code. It reads back the result, the flags that operation would produce, and whether the condition holds. It raises the flag-write enable when the operation should update the status. The condition is always judged against the flags held before that cycle's update. This lets a compare and the branch that depends on it sit in successive cycles.

Top module: `shalu_core`

## Requirements
- R1: The shifter applies to operand B one of four operations chosen by `shift_op`: 0 logical left, 1 logical right, 2 arithmetic right (sign-filling), 3 rotate right. The amount is `shift_amt` (0 to 31). An amount of 0 passes B unchanged.
- R2: The shifter carry is the last bit shifted out. For a left shift by n this is bit (32-n) of B. For right shifts and rotates by n it is bit (n-1) of B. For an amount of 0 it is 0.
- R3: The adder operations are selected by `alu_op`. 0 add gives A+B'. 1 subtract gives A+~B'+1. 4 add-with-carry gives A+B'+C. 5 subtract-with-carry gives A+~B'+C. 6 negate gives 0+~B'+1. B' is the shifted operand and C is the stored carry. For these operations the C flag is the carry out of bit 31.
- R4: For the adder operations the V flag is set when both adder inputs have equal sign bits and the sum's sign bit differs from them.
- R5: `alu_op` 2 AND, 3 XOR, 7 OR, 11 bit-clear (A & ~B') and 8 multiply (low 32 bits of A*B') give C = 0 and V = 0.
- R6: `alu_op` 9 move outputs B' and `alu_op` 10 move-not outputs ~B'. Both ignore operand A, take C from the shifter carry (R2) and give V = 0.
- R7: `alu_op` 12 address-add outputs A+B' with bits 1 and 0 forced to zero, with C = 0 and V = 0.
- R8: N is result bit 31 and Z is 1 exactly when the result is zero. The next-flag vector `flags_next` is ordered {N,Z,C,V}, bit 3 down to bit 0.
- R9: `flags_out` resets to 0000. On a clock edge with `flag_wr` high it loads all four bits of `flags_next`. Otherwise it holds its value.
- R10: `cond_true` evaluates `cond_code` against `flags_out`, which holds the flags from before the current update: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V).
- R11: Condition codes 14 and 15 give `cond_true` = 0. The unused `alu_op` codes 13 to 15 give a zero result with flags {0,1,0,0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First ALU operand |
| op_b | input | 32 | Second operand before the shifter |
| shift_op | input | 2 | Shift operation code |
| shift_amt | input | 5 | Shift amount 0 to 31 |
| alu_op | input | 4 | ALU operation code |
| flag_wr | input | 1 | Load the flag register this cycle |
| cond_code | input | 4 | Branch condition code |
| result | output | 32 | ALU result |
| flags_next | output | 4 | Flags of the current operation {N,Z,C,V} |
| flags_out | output | 4 | Registered flags {N,Z,C,V} |
| cond_true | output | 1 | Condition holds on the registered flags |

## Verification
The bench builds the block with its default 32-bit width, so the 5-bit shift amount spans the full 0 to 31 range. This brings the edge amounts 0, 1 and 31 within reach, together with the carry-out bit at position 32 of the adder. At this width the sign-bit overflow cases (0x7FFFFFFF + 1, 0x80000000 - 1) and the carry-only case (0xFFFFFFFF + 1) are the real boundaries of the datapath. Feeding the add-with-carry and subtract-with-carry operations from flags set by a previous instruction exercises the path from the register back into the adder.

// File: rtl/shalu_pkg.sv
`timescale 1ns/1ps
package shalu_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_op_e;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3,
        OP_ADC = 4'd4,
        OP_SBC = 4'd5,
        OP_NEG = 4'd6,
        OP_OR  = 4'd7,
        OP_MUL = 4'd8,
        OP_MOV = 4'd9,
        OP_MVN = 4'd10,
        OP_BIC = 4'd11,
        OP_ADR = 4'd12,
        OP_R13 = 4'd13,
        OP_R14 = 4'd14,
        OP_R15 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        nzcv_t flags;
    } shalu_state_t;

endpackage

// File: rtl/shalu_shifter.sv
`timescale 1ns/1ps
module shalu_shifter #(
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       sop,
    input  logic [AW-1:0]    amt,
    output logic [WIDTH-1:0] dout,
    output logic             carry
);
    import shalu_pkg::*;

    logic [WIDTH:0]     left_ext;
    logic [WIDTH:0]     right_ext;
    logic [WIDTH:0]     arith_ext;
    logic [2*WIDTH-1:0] rot_ext;

    always_comb begin
        // Left: an extra guard bit on top catches the last bit pushed out.
        left_ext  = {1'b0, din} << amt;
        // Right: a guard bit below the LSB catches the last bit pushed out.
        right_ext = {din, 1'b0} >> amt;
        arith_ext = $unsigned($signed({din, 1'b0}) >>> amt);
        rot_ext   = {din, din} >> amt;
        dout      = din;
        carry     = 1'b0;
        case (shift_op_e'(sop))
            SH_LSL: begin
                dout  = left_ext[WIDTH-1:0];
                carry = left_ext[WIDTH];
            end
            SH_LSR: begin
                dout  = right_ext[WIDTH:1];
                carry = right_ext[0];
            end
            SH_ASR: begin
                dout  = arith_ext[WIDTH:1];
                carry = arith_ext[0];
            end
            default: begin
                dout  = rot_ext[WIDTH-1:0];
                carry = right_ext[0];
            end
        endcase
    end
endmodule

// File: rtl/shalu_alu.sv
`timescale 1ns/1ps
module shalu_alu #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    input  logic             c_in,
    input  logic             sh_carry,
    output logic [WIDTH-1:0] res,
    output logic [3:0]       nzcv
);
    import shalu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_ci;
    logic [WIDTH:0]   sum;
    logic             use_adder;
    logic [WIDTH-1:0] prod;
    logic             c_flag;
    logic             v_flag;

    // Operand preparation for the single shared adder.
    always_comb begin
        add_x     = a;
        add_y     = b;
        add_ci    = 1'b0;
        use_adder = 1'b1;
        case (alu_op_e'(op))
            OP_ADD: begin add_y = b;  add_ci = 1'b0; end
            OP_SUB: begin add_y = ~b; add_ci = 1'b1; end
            OP_ADC: begin add_y = b;  add_ci = c_in; end
            OP_SBC: begin add_y = ~b; add_ci = c_in; end
            OP_NEG: begin add_x = '0; add_y = ~b; add_ci = 1'b1; end
            OP_ADR: begin add_y = b;  add_ci = 1'b0; use_adder = 1'b0; end
            default: use_adder = 1'b0;
        endcase
    end

    assign sum  = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_ci};
    assign prod = a * b;

    always_comb begin
        res    = '0;
        c_flag = 1'b0;
        v_flag = 1'b0;
        case (alu_op_e'(op))
            OP_ADD, OP_SUB, OP_ADC, OP_SBC, OP_NEG: res = sum[WIDTH-1:0];
            OP_AND: res = a & b;
            OP_XOR: res = a ^ b;
            OP_OR:  res = a | b;
            OP_BIC: res = a & ~b;
            OP_MUL: res = prod;
            OP_MOV: begin res = b;  c_flag = sh_carry; end
            OP_MVN: begin res = ~b; c_flag = sh_carry; end
            OP_ADR: res = {sum[WIDTH-1:2], 2'b00};
            default: res = '0;
        endcase
        if (use_adder) begin
            c_flag = sum[WIDTH];
            v_flag = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);
        end
    end

    assign nzcv = {res[MSB], (res == '0), c_flag, v_flag};
endmodule

// File: rtl/shalu_cond.sv
`timescale 1ns/1ps
module shalu_cond (
    input  logic [3:0] code,
    input  logic [3:0] nzcv,
    output logic       hit
);
    logic n, z, c, v;
    logic base;

    assign {n, z, c, v} = nzcv;

    // Even codes test a predicate, odd codes its complement (0..13).
    always_comb begin
        case (code[3:1])
            3'd0:    base = z;
            3'd1:    base = c;
            3'd2:    base = n;
            3'd3:    base = v;
            3'd4:    base = c & ~z;
            3'd5:    base = (n == v);
            3'd6:    base = ~z & (n == v);
            default: base = 1'b0;
        endcase
        if (code[3:1] == 3'd7) hit = 1'b0;
        else                   hit = base ^ code[0];
    end
endmodule

// File: rtl/shalu_core.sv
`timescale 1ns/1ps
module shalu_core #(
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       shift_op,
    input  logic [AW-1:0]    shift_amt,
    input  logic [3:0]       alu_op,
    input  logic             flag_wr,
    input  logic [3:0]       cond_code,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags_next,
    output logic [3:0]       flags_out,
    output logic             cond_true
);
    import shalu_pkg::*;

    shalu_state_t     state_d;
    shalu_state_t     state_q;
    logic [WIDTH-1:0] shifted;
    logic             sh_c;
    logic [3:0]       alu_flags;

    shalu_shifter #(.WIDTH(WIDTH)) u_shift (
        .din   (op_b),
        .sop   (shift_op),
        .amt   (shift_amt),
        .dout  (shifted),
        .carry (sh_c)
    );

    shalu_alu #(.WIDTH(WIDTH)) u_alu (
        .a        (op_a),
        .b        (shifted),
        .op       (alu_op),
        .c_in     (state_q.flags.c),
        .sh_carry (sh_c),
        .res      (result),
        .nzcv     (alu_flags)
    );

    shalu_cond u_cond (
        .code (cond_code),
        .nzcv (state_q.flags),
        .hit  (cond_true)
    );

    always_comb begin
        state_d = state_q;
        if (flag_wr) state_d.flags = nzcv_t'(alu_flags);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags_next = alu_flags;
    assign flags_out  = state_q.flags;
endmodule

// File: rtl/shalu_checker.sv
`timescale 1ns/1ps
module shalu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       alu_op,
    input logic             flag_wr,
    input logic [3:0]       cond_code,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       flags_next,
    input logic [3:0]       flags_out,
    input logic             cond_true
);
    p_adr_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 4'd12) |-> (result[1:0] == 2'b00));

    p_logic_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 4'd2 || alu_op == 4'd3 || alu_op == 4'd7 ||
         alu_op == 4'd8 || alu_op == 4'd11) |-> (flags_next[1:0] == 2'b00));

    p_move_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 4'd9 || alu_op == 4'd10) |-> !flags_next[0]);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> $stable(flags_out));

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> (flags_out == $past(flags_next)));

    p_eq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd0) |-> (cond_true == flags_out[2]));

    p_rsvd_cond_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code[3:1] == 3'b111) |-> !cond_true);
endmodule

bind shalu_core shalu_checker #(.WIDTH(WIDTH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_op     (alu_op),
    .flag_wr    (flag_wr),
    .cond_code  (cond_code),
    .result     (result),
    .flags_next (flags_next),
    .flags_out  (flags_out),
    .cond_true  (cond_true)
);

// File: tb/tb_shalu_core.sv
`timescale 1ns/1ps
module tb_shalu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  shift_op = '0;
    logic [4:0]  shift_amt = '0;
    logic [3:0]  alu_op = '0;
    logic        flag_wr = 1'b0;
    logic [3:0]  cond_code = '0;
    logic [31:0] result;
    logic [3:0]  flags_next;
    logic [3:0]  flags_out;
    logic        cond_true;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [3:0] model_flags = 4'b0000;

    always #2 clk = ~clk;

    shalu_core dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .shift_op(shift_op), .shift_amt(shift_amt), .alu_op(alu_op),
        .flag_wr(flag_wr), .cond_code(cond_code), .result(result),
        .flags_next(flags_next), .flags_out(flags_out), .cond_true(cond_true)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Behavioural reference: returns {nzcv, result}
    function automatic logic [35:0] ref_eval(
        input logic [31:0] a, input logic [31:0] b, input int sop,
        input int n, input int op, input logic cin);
        logic [31:0] sh;
        logic        sc;
        logic [63:0] s;
        logic [31:0] x, y, r;
        logic        ci, c, v, arith;
        sc = 1'b0;
        case (sop)
            0: begin sh = b << n; if (n > 0) sc = b[32-n]; end
            1: begin sh = b >> n; if (n > 0) sc = b[n-1]; end
            2: begin sh = 32'($signed(b) >>> n); if (n > 0) sc = b[n-1]; end
            default: begin
                sh = (n == 0) ? b : ((b >> n) | (b << (32 - n)));
                if (n > 0) sc = b[n-1];
            end
        endcase
        x = a; y = sh; ci = 1'b0; arith = 1'b1; c = 1'b0; v = 1'b0; r = 32'd0;
        case (op)
            0: ;
            1: begin y = ~sh; ci = 1'b1; end
            4: ci = cin;
            5: begin y = ~sh; ci = cin; end
            6: begin x = 32'd0; y = ~sh; ci = 1'b1; end
            default: arith = 1'b0;
        endcase
        s = 64'(x) + 64'(y) + 64'(ci);
        if (arith) begin
            r = s[31:0];
            c = s[32];
            v = (x[31] == y[31]) && (r[31] != x[31]);
        end else begin
            case (op)
                2: r = a & sh;
                3: r = a ^ sh;
                7: r = a | sh;
                8: r = 32'(64'(a) * 64'(sh));
                9: begin r = sh; c = sc; end
                10: begin r = ~sh; c = sc; end
                11: r = a & ~sh;
                12: r = (a + sh) & 32'hFFFF_FFFC;
                default: r = 32'd0;
            endcase
        end
        return {r[31], (r == 32'd0), c, v, r};
    endfunction

    function automatic logic ref_cond(input int code, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (code)
            0: return z;        1: return !z;
            2: return c;        3: return !c;
            4: return n;        5: return !n;
            6: return v;        7: return !v;
            8: return c && !z;  9: return !c || z;
            10: return n == v;  11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1, 4, 5, 6: return "R3";
            2, 3, 7, 8, 11: return "R5";
            9, 10: return "R6";
            12: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic step(input logic [31:0] a, input logic [31:0] b,
                        input int sop, input int n, input int op,
                        input logic wr, input int cc);
        logic [35:0] e;
        @(negedge clk);
        op_a = a; op_b = b; shift_op = 2'(sop); shift_amt = 5'(n);
        alu_op = 4'(op); flag_wr = wr; cond_code = 4'(cc);
        #1;
        e = ref_eval(a, b, sop, n, op, model_flags[1]);
        check(req_of(op), "result", result, e[31:0]);
        check("R8", "N/Z", {30'd0, flags_next[3:2]}, {30'd0, e[35:34]});
        check(op inside {[0:1], [4:6]} ? "R4" : req_of(op), "C/V",
              {30'd0, flags_next[1:0]}, {30'd0, e[33:32]});
        check(cc >= 14 ? "R11" : "R10", "cond_true",
              {31'd0, cond_true}, {31'd0, ref_cond(cc, model_flags)});
        @(posedge clk);
        if (wr) model_flags = e[35:32];
        #1;
        check("R9", "flags_out", {28'd0, flags_out}, {28'd0, model_flags});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9", "reset flags", {28'd0, flags_out}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 R2: every shift op at edge amounts, moved through MOV/MVN (R6)
        for (int s = 0; s < 4; s++) begin
            step(32'hDEAD_BEEF, 32'h8000_0001, s, 0, 9, 1, 2);
            step(32'h1234_5678, 32'h8000_0001, s, 1, 9, 1, 2);
            step(32'h0, 32'h4000_0003, s, 31, 10, 1, 3);
            step(32'hFFFF_FFFF, 32'hC3A5_0F96, s, 17, 9, 1, 2);
        end
        // R3 R4 adder corners
        step(32'h7FFF_FFFF, 32'h1, 0, 0, 0, 1, 6);
        step(32'hFFFF_FFFF, 32'h1, 0, 0, 0, 1, 2);
        step(32'h8000_0000, 32'h1, 0, 0, 1, 1, 6);
        step(32'h5, 32'h5, 0, 0, 1, 1, 0);
        step(32'h3, 32'h5, 0, 0, 1, 1, 11);
        step(32'h0, 32'h0, 0, 0, 6, 1, 2);
        step(32'h0, 32'h1, 0, 0, 6, 1, 4);
        step(32'hFFFF_FFFF, 32'h0, 0, 0, 0, 1, 0);
        step(32'h10, 32'h20, 0, 0, 4, 1, 2);
        step(32'h10, 32'h20, 0, 0, 5, 1, 3);
        step(32'hFFFF_FFFF, 32'h1, 0, 0, 0, 1, 8);
        step(32'h10, 32'h20, 0, 0, 4, 1, 9);
        step(32'h10, 32'h10, 0, 0, 5, 0, 12);
        // R7 address add with scaled offset
        step(32'h0000_1003, 32'h0000_0007, 0, 2, 12, 0, 13);
        step(32'hFFFF_FFFE, 32'h3, 0, 0, 12, 1, 1);
        // R11 unused ops and codes
        step(32'h1234, 32'h5678, 0, 0, 13, 1, 14);
        step(32'h1234, 32'h5678, 0, 0, 15, 0, 15);
        // R9 hold: flag_wr low must not disturb flags
        step(32'h0, 32'h0, 0, 0, 1, 0, 1);
        // R10 all condition codes on several flag states
        for (int k = 0; k < 16; k++) begin
            step(32'h8000_0000, 32'h8000_0000, 0, 0, 0, 1, k);
            step(32'h8000_0000, 32'h1, 0, 0, 1, 1, k);
            step(32'h0, 32'h0, 0, 0, 1, 1, k);
            step(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 1, k);
        end
        // random sweep over all ops, shifts and conditions
        for (int i = 0; i < 3000; i++)
            step($urandom, $urandom, int'($urandom % 4), int'($urandom % 32),
                 int'($urandom % 16), 1'($urandom), int'($urandom % 16));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule